// File: doc/BRIEF.md
# Wavetable Tone Generator with One-Bit Density Output

This block plays one of four stored periodic waveforms and emits it as a one-bit pulse-density stream. An external low-pass network, such as a speaker or headphone coil, turns that stream back into an analogue level.

A free-running phase counter is sliced to address the table, so the tone pitch is a fixed fraction of the clock. Every 64 clocks a new 8-bit sample is fetched from the bank that the waveform selector picks. The sample is converted to a signed offset from mid-scale and attenuated by an arithmetic right shift. It is then re-centred in a 12-bit word, so the bits that the shift moves down are kept rather than lost.

A first-order accumulator adds that word on every clock. Its carry-out, registered, is the output pin. The long-run density of ones equals the 12-bit input divided by 4096.

Top module: `wavetone_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the phase counter and the accumulator and drives `pdmOut` to 0. It also loads the sample register with mid-scale 128. `pdmOut` is 0 during reset and after the first clock edge following release.
- R2: The phase counter is 14 bits wide and its bits [13:6] form the phase, so a full waveform period is 16384 clocks. The sample for phase p is read into a register one edge after the counter shows it, and drives the accumulator on edges 64p+2 through 64p+65 after reset release (edge 1 is the first edge with `rst` low). The phase wraps from 255 to 0.
- R3: `waveSel` forms the two upper bits of the 10-bit table address, with the phase as the lower 8 bits. The codes are 0 sine, 1 square, 2 rising sawtooth, 3 falling ramp.
- R4: The sine bank is built as follows. Let q = p mod 128, a = q*(127-q)*100/4032 in integer division, and s = 128+a for p<128 or 128-a otherwise. Values therefore stay within 28..228.
- R5: The square bank holds 228 for p<128 and 28 otherwise. The sawtooth bank holds 28 + p*200/255 and the ramp bank holds 228 - p*200/255, both in integer division.
- R6: The 12-bit modulator input is ((s-128)*16 >>> `volShift`) + 2048, using an arithmetic shift. With `volShift` 0 it equals s*16, the 8-bit sample in the upper bits with four zero low bits.
- R7: On each edge the accumulator forms sum = acc + input in 13 bits, keeps sum[11:0] and registers sum[12] as `pdmOut`.
- R8: An input of exactly 2048, such as mid-scale after reset, gives the stream 0,1,0,1,... starting from the first edge after reset release.
- R9: Over each 64-edge window of one sample, the count of ones c satisfies |64c - input| < 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| waveSel | input | 2 | Waveform bank select (0 sine, 1 square, 2 sawtooth, 3 ramp) |
| volShift | input | 2 | Attenuation as an arithmetic right shift of 0 to 3 places |
| pdmOut | output | 1 | One-bit pulse-density output stream |

## Verification
The bench runs a bit-exact model of the accumulator over a whole waveform period and beyond the phase wrap. A one-clock error in the sample latency, a wrong phase slice or a swapped bank code therefore shows up as a mismatched window rather than as a small density drift. Attenuated runs catch a logical shift in place of an arithmetic one: with a logical shift, samples below mid-scale turn into near-full-scale densities. Dropping the low bits after the shift produces bit-stream mismatches even where the density stays within tolerance. The half-scale check from reset catches a sample register that resets to zero, or an accumulator that starts anywhere other than zero, because either breaks the strict 0,1 alternation.

// File: rtl/wt_pkg.sv
package wt_pkg;

  localparam int SAMPLE_BITS = 8;
  localparam int PHASE_BITS  = 8;
  localparam int SEL_BITS    = 2;
  localparam int HOLD_BITS   = 6;
  localparam int MOD_BITS    = 12;
  localparam int VOL_BITS    = 2;

  localparam int MID_LEVEL   = 128;
  localparam int LOW_LEVEL   = 28;
  localparam int HIGH_LEVEL  = 228;
  localparam int SINE_AMP    = 100;

  typedef enum logic [SEL_BITS-1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_SAW    = 2'd2,
    WAVE_RAMP   = 2'd3
  } wave_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic                  load;
    logic [PHASE_BITS-1:0] phase;
  } strobe_t;

  // one table entry, computed; the ROM is built from these constants
  function automatic logic [SAMPLE_BITS-1:0] waveValue(
    input logic [SEL_BITS-1:0]   sel,
    input logic [PHASE_BITS-1:0] ph
  );
    int half;
    int peak;
    int q;
    int bend;
    int v;
    int span;
    half = 1 << (PHASE_BITS - 1);
    peak = ((half - 1) / 2) * (half / 2);
    span = (1 << PHASE_BITS) - 1;
    q    = int'(ph) % half;
    bend = (q * (half - 1 - q) * SINE_AMP) / peak;
    case (wave_e'(sel))
      WAVE_SINE:   v = (int'(ph) >= half) ? MID_LEVEL - bend : MID_LEVEL + bend;
      WAVE_SQUARE: v = (int'(ph) >= half) ? LOW_LEVEL : HIGH_LEVEL;
      WAVE_SAW:    v = LOW_LEVEL + (int'(ph) * (HIGH_LEVEL - LOW_LEVEL)) / span;
      default:     v = HIGH_LEVEL - (int'(ph) * (HIGH_LEVEL - LOW_LEVEL)) / span;
    endcase
    return SAMPLE_BITS'(v);
  endfunction

endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int PHASE_W = PHASE_BITS,
  parameter int HOLD_W  = HOLD_BITS
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobe
);

  localparam int CNT_W = PHASE_W + HOLD_W;

  logic [CNT_W-1:0] phaseCount;

  // free-running phase counter; wraps every 2**CNT_W clocks
  always_ff @(posedge clk) begin
    if (rst) phaseCount <= '0;
    else     phaseCount <= phaseCount + 1'b1;
  end

  // a new sample is fetched whenever the hold bits are all zero
  always_comb begin
    strobe.load  = (phaseCount[HOLD_W-1:0] == '0);
    strobe.phase = phaseCount[CNT_W-1:HOLD_W];
  end

endmodule

// File: rtl/wt_wavetable.sv
module wt_wavetable
  import wt_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_BITS,
  parameter int PHASE_W  = PHASE_BITS,
  parameter int SEL_W    = SEL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SEL_W-1:0]    bank,
  input  logic [PHASE_W-1:0]  phase,
  output logic [SAMPLE_W-1:0] sampleQ
);

  localparam int ADDR_W    = SEL_W + PHASE_W;
  localparam int ROM_DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] romWord [ROM_DEPTH];
  logic [ADDR_W-1:0]   romAddr;

  // constant contents, one entry per bank and phase
  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    localparam logic [SEL_W-1:0]   BANK_I  = SEL_W'(i >> PHASE_W);
    localparam logic [PHASE_W-1:0] PHASE_I = PHASE_W'(i);
    assign romWord[i] = SAMPLE_W'(waveValue(BANK_I, PHASE_I));
  end

  // the bank select forms the upper address bits
  assign romAddr = {bank, phase};

  // registered read; held between load strobes, mid-scale after reset
  always_ff @(posedge clk) begin
    if (rst)       sampleQ <= SAMPLE_W'(MID_LEVEL);
    else if (load) sampleQ <= romWord[romAddr];
  end

endmodule

// File: rtl/wt_volume.sv
module wt_volume
  import wt_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_BITS,
  parameter int MOD_W    = MOD_BITS,
  parameter int VOL_W    = VOL_BITS
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [VOL_W-1:0]    volShift,
  output logic [MOD_W-1:0]    modIn
);

  localparam int FRAC_W = MOD_W - SAMPLE_W;

  logic [MOD_W-1:0] centered;
  logic [MOD_W-1:0] shifted;

  always_comb begin
    // subtract mid-scale: flipping the top bit is the offset-binary to signed step
    if (FRAC_W > 0) centered = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0], {FRAC_W{1'b0}}};
    else            centered = MOD_W'({~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]});
    // sign-extending shift keeps the low bits inside the wider word
    shifted = MOD_W'($signed(centered) >>> volShift);
    // back to offset binary around mid-scale
    modIn   = {~shifted[MOD_W-1], shifted[MOD_W-2:0]};
  end

endmodule

// File: rtl/wt_modulator.sv
module wt_modulator
  import wt_pkg::*;
#(
  parameter int MOD_W = MOD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] modIn,
  output logic             pdmOut
);

  logic [MOD_W-1:0] acc;
  logic [MOD_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, modIn};

  // first-order loop: the carry is the output bit, the remainder is kept
  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      pdmOut <= 1'b0;
    end else begin
      acc    <= sum[MOD_W-1:0];
      pdmOut <= sum[MOD_W];
    end
  end

endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_BITS,
  parameter int PHASE_W  = PHASE_BITS,
  parameter int SEL_W    = SEL_BITS,
  parameter int MOD_W    = MOD_BITS,
  parameter int VOL_W    = VOL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobe,
  input  logic [SEL_W-1:0]    waveSel,
  input  logic [VOL_W-1:0]    volShift,
  output logic [SAMPLE_W-1:0] sampleQ,
  output logic [MOD_W-1:0]    modIn,
  output logic                pdmOut
);

  wt_wavetable #(
    .SAMPLE_W(SAMPLE_W),
    .PHASE_W (PHASE_W),
    .SEL_W   (SEL_W)
  ) u_table (
    .clk    (clk),
    .rst    (rst),
    .load   (strobe.load),
    .bank   (waveSel),
    .phase  (strobe.phase),
    .sampleQ(sampleQ)
  );

  wt_volume #(
    .SAMPLE_W(SAMPLE_W),
    .MOD_W   (MOD_W),
    .VOL_W   (VOL_W)
  ) u_volume (
    .sample  (sampleQ),
    .volShift(volShift),
    .modIn   (modIn)
  );

  wt_modulator #(
    .MOD_W(MOD_W)
  ) u_mod (
    .clk   (clk),
    .rst   (rst),
    .modIn (modIn),
    .pdmOut(pdmOut)
  );

endmodule

// File: rtl/wavetone_top.sv
module wavetone_top
  import wt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] waveSel,
  input  logic [1:0] volShift,
  output logic       pdmOut
);

  strobe_t                strobe;
  logic                   loadStrobe;
  logic [SAMPLE_BITS-1:0] sampleQ;
  logic [MOD_BITS-1:0]    modIn;

  assign loadStrobe = strobe.load;

  wt_ctrl #(
    .PHASE_W(PHASE_BITS),
    .HOLD_W (HOLD_BITS)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe)
  );

  wt_datapath #(
    .SAMPLE_W(SAMPLE_BITS),
    .PHASE_W (PHASE_BITS),
    .SEL_W   (SEL_BITS),
    .MOD_W   (MOD_BITS),
    .VOL_W   (VOL_BITS)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .waveSel (waveSel),
    .volShift(volShift),
    .sampleQ (sampleQ),
    .modIn   (modIn),
    .pdmOut  (pdmOut)
  );

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int SAMPLE_W = 8,
  parameter int MOD_W    = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                loadStrobe,
  input logic [SAMPLE_W-1:0] sampleQ,
  input logic [MOD_W-1:0]    modIn,
  input logic [1:0]          volShift,
  input logic                pdmOut
);

  localparam logic [MOD_W-1:0] HALF_IN = MOD_W'(1 << (MOD_W - 1));

  // R1: first output after release is zero
  p_first_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pdmOut);

  // R2: the sample only changes right after a load strobe
  p_sample_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !loadStrobe |=> $stable(sampleQ));

  // R2: load strobes never come on adjacent clocks
  p_load_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    loadStrobe |=> !loadStrobe);

  // R6: no attenuation places the sample in the upper bits
  p_unity_scale_r6: assert property (@(posedge clk) disable iff (rst)
    (volShift == 2'd0) |-> (modIn == {sampleQ, {(MOD_W - SAMPLE_W){1'b0}}}));

  // R6: mid-scale stays mid-scale at every volume
  p_mid_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    (sampleQ == SAMPLE_W'(128)) |-> (modIn == HALF_IN));

  // R7: at or below half input no two ones follow each other
  p_no_double_one_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pdmOut && $stable(modIn) && modIn <= HALF_IN) |=> !pdmOut);

  // R7: at or above half input no two zeros follow each other
  p_no_double_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !pdmOut && $stable(modIn) && modIn >= HALF_IN) |=> pdmOut);

endmodule

bind wavetone_top wt_checker #(
  .SAMPLE_W(wt_pkg::SAMPLE_BITS),
  .MOD_W   (wt_pkg::MOD_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loadStrobe(loadStrobe),
  .sampleQ   (sampleQ),
  .modIn     (modIn),
  .volShift  (volShift),
  .pdmOut    (pdmOut)
);

// File: tb/sim_wavetone_top.sv
module sim_wavetone_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] waveSel = 2'd0;
  logic [1:0] volShift = 2'd0;
  logic       pdmOut;

  int nChecks = 0;
  int nErrs   = 0;

  wavetone_top u0 (
    .clk     (clk),
    .rst     (rst),
    .waveSel (waveSel),
    .volShift(volShift),
    .pdmOut  (pdmOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // table contents as written in R4 and R5
  function automatic int expSample(input int sel, input int p);
    int q;
    int a;
    q = p % 128;
    a = (q * (127 - q) * 100) / 4032;
    case (sel)
      0:       return (p < 128) ? 128 + a : 128 - a;
      1:       return (p < 128) ? 228 : 28;
      2:       return 28 + (p * 200) / 255;
      default: return 228 - (p * 200) / 255;
    endcase
  endfunction

  // modulator input as written in R6
  function automatic int expMod(input int s, input int sh);
    int c;
    c = (s - 128) * 16;
    c = c >>> sh;
    return c + 2048;
  endfunction

  task automatic applyReset(input int sel, input int sh);
    @(negedge clk);
    rst = 1'b1;
    waveSel = 2'(sel);
    volShift = 2'(sh);
    repeat (4) @(negedge clk);
    check(pdmOut == 1'b0, "R1 output held low in reset", int'(pdmOut), 0);
    rst = 1'b0;
  endtask

  // bit-exact run over nWin sample windows with a reference accumulator
  task automatic runWave(input int sel, input int sh, input int nWin);
    int refAcc;
    int sum;
    int in;
    int p;
    int ones;
    int mism;
    bit refOut;
    string tag;
    tag = (sel == 0) ? "R4" : "R5";
    applyReset(sel, sh);
    refAcc = 0;
    ones = 0;
    mism = 0;
    for (int k = 1; k <= 64 * nWin + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        in = expMod(128, sh);
        p  = 0;
      end else begin
        p  = ((k - 2) / 64) % 256;
        in = expMod(expSample(sel, p), sh);
      end
      sum    = refAcc + in;
      refOut = (sum >= 4096);
      refAcc = sum % 4096;
      if (k == 1) begin
        check(pdmOut == 1'b0, "R1 first output after release", int'(pdmOut), 0);
      end else begin
        if (pdmOut !== refOut) mism++;
        ones += int'(pdmOut);
        if (((k - 2) % 64) == 63) begin
          check(mism == 0,
                $sformatf("R2 R3 %s R6 R7 bit stream sel=%0d sh=%0d phase=%0d", tag, sel, sh, p),
                mism, 0);
          check((ones * 64 - in) > -64 && (ones * 64 - in) < 64,
                $sformatf("R9 density sel=%0d sh=%0d phase=%0d", sel, sh, p),
                ones, in / 64);
          ones = 0;
          mism = 0;
        end
      end
    end
  endtask

  // mid-scale from reset must alternate 0,1,0,1
  task automatic runHalfScale(input int sh);
    applyReset(0, sh);
    for (int k = 1; k <= 65; k++) begin
      @(negedge clk);
      check(pdmOut == ((k % 2) == 0), $sformatf("R8 half-scale edge %0d sh=%0d", k, sh),
            int'(pdmOut), int'((k % 2) == 0));
    end
  endtask

  initial begin
    runHalfScale(0);
    runHalfScale(3);
    // full periods plus a wrap into phase 0 and 1 at unity volume
    runWave(0, 0, 258);
    runWave(1, 0, 258);
    runWave(2, 0, 258);
    runWave(3, 0, 258);
    // attenuated runs (R6)
    runWave(0, 1, 64);
    runWave(0, 2, 64);
    runWave(0, 3, 160);
    runWave(3, 3, 64);
    runWave(1, 2, 140);
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    nErrs++;
    nChecks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule